// File: doc/BRIEF.md
# Slowdown-Balancing DRAM Request Scheduler

This block picks one request per cycle from the request buffer of a DRAM controller that several hardware threads share. For each thread it keeps a count of the cycles that thread spent waiting under sharing. It also takes an externally supplied estimate of the stall cycles the same thread would have seen running alone. The slowdown of a thread is its shared count divided by its alone estimate. No divider is used: every ratio comparison is done by cross-multiplication.

Each cycle the block finds the most and least slowed threads among those with a pending request and forms the unfairness, which is the largest slowdown over the smallest. It compares this with a programmable threshold. Below the threshold it runs a throughput policy: row hits first, then the oldest request. At or above the threshold it runs a fairness policy: requests of the most slowed thread first, then row hits, then age. The grant is combinational from the current buffer contents and counter state. The counters advance on the clock edge.

Top module: `slowbal_sched`

## Requirements
- R1: When no buffer entry is valid, `grant_valid` and `fair_mode` are 0. Otherwise `grant_valid` is 1 and `grant_idx` names a valid entry.
- R2: An entry is a row hit when `bank_open[b]` is 1 and `bank_row[b]` equals its row, where b is its bank. In throughput mode a row hit beats any non-hit, and among equals the larger `req_age` (older) wins.
- R3: Entries with an identical priority key are resolved in favour of the lowest buffer index.
- R4: Slowdown of thread t is stall(t)/alone(t). An `alone_est` of 0 is used as 1. Ratios are compared as stall(i)*alone(j) against stall(j)*alone(i).
- R5: Over threads with at least one valid entry, let M be the most slowed and m the least slowed. `fair_mode` is 1 exactly when stall(M) > 0 and stall(M)*alone(m)*16 >= `unfair_thr`*stall(m)*alone(M). The threshold therefore carries 4 fractional bits.
- R6: In fair mode, entries of thread M come first, then row hits, then age. When slowdowns tie for the largest, M is the lowest thread ID.
- R7: Each thread's stall count is 0 after reset. It rises by 1 on each cycle in which the thread has a valid entry and the grant goes to a different thread. It saturates at its maximum value and otherwise holds.
- R8: Grant and mode follow the inputs and counter state of the same cycle, and the comparison is redone every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NE | Entry holds a request |
| req_tid | input | NE x TW | Thread of each entry |
| req_bank | input | NE x BW | Target bank of each entry |
| req_row | input | NE x RW | Target row of each entry |
| req_age | input | NE x AW | Age of each entry, larger is older |
| bank_open | input | NB | Bank has an open row |
| bank_row | input | NB x RW | Open row of each bank |
| alone_est | input | NT x SW | Estimated alone stall cycles per thread |
| unfair_thr | input | THR_W | Unfairness threshold, 4 fractional bits |
| grant_valid | output | 1 | A request is chosen |
| grant_idx | output | IW | Index of the chosen entry |
| fair_mode | output | 1 | Fairness policy in force |

## Verification
The assertions take for granted that `req_tid` and `req_bank` of a valid entry lie inside the thread and bank ranges. They also assume the inputs stay stable between clock edges, so a grant seen in one cycle is the grant the counters act on. The stimulus draws thread and bank fields modulo their counts and changes every input only at the falling edge. Row, age and estimate values come from small ranges so that hits, age ties, zero estimates and both policies all occur often.

// File: rtl/slowbal_pkg.sv
package slowbal_pkg;
    localparam int unsigned FRAC_W = 4;

    typedef enum logic {
        POL_THRU = 1'b0,
        POL_FAIR = 1'b1
    } policy_e;
endpackage

// File: rtl/slowbal_stall_track.sv
module slowbal_stall_track #(
    parameter int NT = 4,
    parameter int SW = 16,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NT-1:0]          thr_active,
    input  logic                   grant_valid,
    input  logic [TW-1:0]          grant_tid,
    output logic [NT-1:0][SW-1:0]  stall
);
    typedef struct packed {
        logic [NT-1:0][SW-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        for (int t = 0; t < NT; t++) begin
            if (thr_active[t] && !(grant_valid && grant_tid == TW'(t))
                && (trk_q.cnt[t] != {SW{1'b1}})) begin
                trk_d.cnt[t] = trk_q.cnt[t] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign stall = trk_q.cnt;

    for (genvar g = 0; g < NT; g++) begin : g_chk
        // R7: a full counter stays full
        a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            (trk_q.cnt[g] == {SW{1'b1}}) |=> (trk_q.cnt[g] == {SW{1'b1}}));
        // R7: a thread that was served does not accumulate stall
        a_r7_served_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_valid && grant_tid == TW'(g)) |=> $stable(trk_q.cnt[g]));
        // R7: a thread with nothing pending does not accumulate stall
        a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !thr_active[g] |=> $stable(trk_q.cnt[g]));
    end
endmodule

// File: rtl/slowbal_fair_eval.sv
module slowbal_fair_eval
    import slowbal_pkg::*;
#(
    parameter int NT    = 4,
    parameter int SW    = 16,
    parameter int THR_W = 8,
    localparam int TW   = (NT > 1) ? $clog2(NT) : 1,
    localparam int PW   = 2 * SW,
    localparam int UW   = 2 * SW + THR_W + FRAC_W
) (
    input  logic [NT-1:0]          thr_active,
    input  logic [NT-1:0][SW-1:0]  stall,
    input  logic [NT-1:0][SW-1:0]  alone_est,
    input  logic [THR_W-1:0]       unfair_thr,
    output logic                   fair_mode,
    output logic [TW-1:0]          worst_tid
);
    logic [NT-1:0][SW-1:0] alone_eff;
    logic [TW-1:0]         mx, mn;
    logic                  any;
    logic [UW-1:0]         lhs, rhs;

    always_comb begin
        for (int t = 0; t < NT; t++) begin
            alone_eff[t] = (alone_est[t] == '0) ? SW'(1) : alone_est[t];
        end
    end

    // most and least slowed active threads, ties keep the lower ID
    always_comb begin
        any = 1'b0;
        mx  = '0;
        mn  = '0;
        for (int t = 0; t < NT; t++) begin
            if (thr_active[t]) begin
                if (!any) begin
                    mx = TW'(t);
                    mn = TW'(t);
                end else begin
                    if (PW'(stall[t]) * PW'(alone_eff[mx]) >
                        PW'(stall[mx]) * PW'(alone_eff[t])) mx = TW'(t);
                    if (PW'(stall[t]) * PW'(alone_eff[mn]) <
                        PW'(stall[mn]) * PW'(alone_eff[t])) mn = TW'(t);
                end
                any = 1'b1;
            end
        end
    end

    always_comb begin
        lhs = (UW'(stall[mx]) * UW'(alone_eff[mn])) << FRAC_W;
        rhs = UW'(unfair_thr) * UW'(stall[mn]) * UW'(alone_eff[mx]);
    end

    assign fair_mode = any && (stall[mx] != '0) && (lhs >= rhs);
    assign worst_tid = mx;
endmodule

// File: rtl/slowbal_pick.sv
module slowbal_pick
    import slowbal_pkg::*;
#(
    parameter int NE = 8,
    parameter int NB = 4,
    parameter int RW = 8,
    parameter int AW = 8,
    parameter int TW = 2,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1,
    localparam int IW = (NE > 1) ? $clog2(NE) : 1,
    localparam int KW = AW + 2
) (
    input  logic [NE-1:0]          req_valid,
    input  logic [NE-1:0][TW-1:0]  req_tid,
    input  logic [NE-1:0][BW-1:0]  req_bank,
    input  logic [NE-1:0][RW-1:0]  req_row,
    input  logic [NE-1:0][AW-1:0]  req_age,
    input  logic [NB-1:0]          bank_open,
    input  logic [NB-1:0][RW-1:0]  bank_row,
    input  logic                   fair_mode,
    input  logic [TW-1:0]          worst_tid,
    output logic                   grant_valid,
    output logic [IW-1:0]          grant_idx
);
    policy_e              pol;
    logic [NE-1:0][KW-1:0] key;
    logic [KW-1:0]        best;

    assign pol = fair_mode ? POL_FAIR : POL_THRU;

    always_comb begin
        for (int e = 0; e < NE; e++) begin
            key[e] = {(pol == POL_FAIR) && (req_tid[e] == worst_tid),
                      bank_open[req_bank[e]] && (bank_row[req_bank[e]] == req_row[e]),
                      req_age[e]};
        end
    end

    // ascending scan with strict compare keeps the lowest index on ties
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        best        = '0;
        for (int e = 0; e < NE; e++) begin
            if (req_valid[e] && (!grant_valid || key[e] > best)) begin
                grant_valid = 1'b1;
                grant_idx   = IW'(e);
                best        = key[e];
            end
        end
    end
endmodule

// File: rtl/slowbal_sched.sv
module slowbal_sched #(
    parameter int NT    = 4,
    parameter int NE    = 8,
    parameter int NB    = 4,
    parameter int RW    = 8,
    parameter int AW    = 8,
    parameter int SW    = 16,
    parameter int THR_W = 8,
    localparam int TW   = (NT > 1) ? $clog2(NT) : 1,
    localparam int BW   = (NB > 1) ? $clog2(NB) : 1,
    localparam int IW   = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NE-1:0]          req_valid,
    input  logic [NE-1:0][TW-1:0]  req_tid,
    input  logic [NE-1:0][BW-1:0]  req_bank,
    input  logic [NE-1:0][RW-1:0]  req_row,
    input  logic [NE-1:0][AW-1:0]  req_age,
    input  logic [NB-1:0]          bank_open,
    input  logic [NB-1:0][RW-1:0]  bank_row,
    input  logic [NT-1:0][SW-1:0]  alone_est,
    input  logic [THR_W-1:0]       unfair_thr,
    output logic                   grant_valid,
    output logic [IW-1:0]          grant_idx,
    output logic                   fair_mode
);
    logic [NT-1:0]         thr_active;
    logic [NT-1:0][SW-1:0] stall;
    logic [TW-1:0]         worst_tid;
    logic [TW-1:0]         grant_tid;
    logic [NE-1:0]         hit_mask;

    always_comb begin
        thr_active = '0;
        for (int e = 0; e < NE; e++) begin
            if (req_valid[e]) thr_active[req_tid[e]] = 1'b1;
        end
    end

    always_comb begin
        for (int e = 0; e < NE; e++) begin
            hit_mask[e] = req_valid[e] && bank_open[req_bank[e]]
                          && (bank_row[req_bank[e]] == req_row[e]);
        end
    end

    assign grant_tid = req_tid[grant_idx];

    slowbal_stall_track #(.NT(NT), .SW(SW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_active  (thr_active),
        .grant_valid (grant_valid),
        .grant_tid   (grant_tid),
        .stall       (stall)
    );

    slowbal_fair_eval #(.NT(NT), .SW(SW), .THR_W(THR_W)) u_eval (
        .thr_active (thr_active),
        .stall      (stall),
        .alone_est  (alone_est),
        .unfair_thr (unfair_thr),
        .fair_mode  (fair_mode),
        .worst_tid  (worst_tid)
    );

    slowbal_pick #(.NE(NE), .NB(NB), .RW(RW), .AW(AW), .TW(TW)) u_pick (
        .req_valid   (req_valid),
        .req_tid     (req_tid),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_age     (req_age),
        .bank_open   (bank_open),
        .bank_row    (bank_row),
        .fair_mode   (fair_mode),
        .worst_tid   (worst_tid),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    // R1: empty buffer gives neither a grant nor fairness mode
    a_r1_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_valid) |-> (!grant_valid && !fair_mode));
    // R1: a grant always names a valid entry
    a_r1_grant_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> req_valid[grant_idx]);
    // R1: any valid entry produces a grant
    a_r1_busy_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |-> grant_valid);
    // R6: fairness mode serves the most slowed thread
    a_r6_worst_served: assert property (@(posedge clk) disable iff (!rst_n)
        fair_mode |-> (grant_valid && grant_tid == worst_tid));
    // R2: throughput mode never passes over a pending row hit
    a_r2_hit_preferred: assert property (@(posedge clk) disable iff (!rst_n)
        (!fair_mode && (|hit_mask)) |-> hit_mask[grant_idx]);
endmodule

// File: tb/slowbal_sched_tb.sv
module slowbal_sched_tb;
    localparam int NT = 4, NE = 8, NB = 4, RW = 8, AW = 8, SW = 16, THR_W = 8;
    localparam int TW = 2, BW = 2, IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NE-1:0]          req_valid;
    logic [NE-1:0][TW-1:0]  req_tid;
    logic [NE-1:0][BW-1:0]  req_bank;
    logic [NE-1:0][RW-1:0]  req_row;
    logic [NE-1:0][AW-1:0]  req_age;
    logic [NB-1:0]          bank_open;
    logic [NB-1:0][RW-1:0]  bank_row;
    logic [NT-1:0][SW-1:0]  alone_est;
    logic [THR_W-1:0]       unfair_thr;
    logic                   grant_valid;
    logic [IW-1:0]          grant_idx;
    logic                   fair_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    longint unsigned m_stall [NT];

    always #2 clk = ~clk;

    slowbal_sched #(.NT(NT), .NE(NE), .NB(NB), .RW(RW), .AW(AW), .SW(SW),
                    .THR_W(THR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
        .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
        .bank_open(bank_open), .bank_row(bank_row), .alone_est(alone_est),
        .unfair_thr(unfair_thr), .grant_valid(grant_valid),
        .grant_idx(grant_idx), .fair_mode(fair_mode)
    );

    function automatic longint unsigned aeff(int t);
        return (alone_est[t] == 0) ? 64'd1 : longint'(alone_est[t]);
    endfunction

    function automatic bit is_hit(int e);
        return bank_open[req_bank[e]] && (bank_row[req_bank[e]] == req_row[e]);
    endfunction

    // expected grant and mode from the requirements
    task automatic model(output bit ev, output int ei, output bit efm, output int etid);
        bit act [NT];
        bit any = 0;
        int mx = 0, mn = 0;
        longint unsigned best;
        longint unsigned k;
        for (int t = 0; t < NT; t++) act[t] = 0;
        for (int e = 0; e < NE; e++) if (req_valid[e]) act[req_tid[e]] = 1;
        for (int t = 0; t < NT; t++) begin
            if (act[t]) begin
                if (!any) begin mx = t; mn = t; end
                else begin
                    if (m_stall[t] * aeff(mx) > m_stall[mx] * aeff(t)) mx = t;
                    if (m_stall[t] * aeff(mn) < m_stall[mn] * aeff(t)) mn = t;
                end
                any = 1;
            end
        end
        efm = any && (m_stall[mx] != 0) &&
              (m_stall[mx] * aeff(mn) * 16 >= longint'(unfair_thr) * m_stall[mn] * aeff(mx));
        ev = 0; ei = 0; best = 0; etid = -1;
        for (int e = 0; e < NE; e++) begin
            k = longint'(req_age[e]) + (is_hit(e) ? 256 : 0)
                + ((efm && req_tid[e] == mx) ? 512 : 0);
            if (req_valid[e] && (!ev || k > best)) begin
                ev = 1; ei = e; best = k; etid = req_tid[e];
            end
        end
    endtask

    task automatic step(string tag, bit upd);
        bit ev, efm;
        int ei, etid;
        bit act [NT];
        #1;
        model(ev, ei, efm, etid);
        checks++;
        if (grant_valid !== ev || (ev && grant_idx !== IW'(ei)) || fair_mode !== efm) begin
            errors++;
            $display("FAIL %s: got valid=%0b idx=%0d fair=%0b, expected valid=%0b idx=%0d fair=%0b",
                     tag, grant_valid, grant_idx, fair_mode, ev, ei, efm);
        end
        if (upd) begin
            for (int t = 0; t < NT; t++) act[t] = 0;
            for (int e = 0; e < NE; e++) if (req_valid[e]) act[req_tid[e]] = 1;
            for (int t = 0; t < NT; t++)
                if (act[t] && etid != t && m_stall[t] != 65535) m_stall[t]++;
        end
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        req_valid = '0; req_tid = '0; req_bank = '0; req_row = '0; req_age = '0;
        bank_open = '0; bank_row = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int t = 0; t < NT; t++) m_stall[t] = 0;
        clear_inputs();
        alone_est = {NT{SW'(1)}};
        unfair_thr = 8'd16;
        repeat (3) @(negedge clk);
        step("R1 reset idle", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        step("R1 empty buffer", 1'b1);

        // R3: identical keys resolve to lowest index; R7: zero counters after reset
        req_valid[2] = 1; req_valid[5] = 1;
        req_bank[2] = 0; req_bank[5] = 1; req_age[2] = 3; req_age[5] = 3;
        step("R3 age tie", 1'b1);

        // R2: row hit beats older non-hit
        clear_inputs();
        req_valid[1] = 1; req_age[1] = 9; req_bank[1] = 0; req_row[1] = 1;
        req_valid[4] = 1; req_age[4] = 1; req_bank[4] = 2; req_row[4] = 5;
        bank_open[2] = 1; bank_row[2] = 5;
        step("R2 hit over age", 1'b1);

        // R7/R5: thread 1 waits behind older thread 0, then fairness takes over
        clear_inputs();
        req_valid[0] = 1; req_tid[0] = 0; req_age[0] = 7; req_bank[0] = 0; req_row[0] = 3;
        req_valid[3] = 1; req_tid[3] = 1; req_age[3] = 2; req_bank[3] = 1;
        for (int i = 0; i < 3; i++) step("R7 stall accrual / R5 mode", 1'b1);

        // R6: make thread 0 a row hit, worst thread still wins in fair mode
        bank_open[0] = 1; bank_row[0] = 3;
        step("R6 worst thread over hit", 1'b1);
        unfair_thr = 8'd255;
        step("R5 high threshold", 1'b1);

        // R4: zero alone estimate acts as one
        alone_est[1] = 0; alone_est[0] = 3;
        step("R4 zero estimate", 1'b1);
        unfair_thr = 8'd0;
        step("R5 zero threshold", 1'b1);

        // R8: constrained random traffic
        for (int c = 0; c < 3000; c++) begin
            if (c % 40 == 0) begin
                for (int t = 0; t < NT; t++) alone_est[t] = SW'($urandom % 6);
                case ($urandom % 5)
                    0: unfair_thr = 8'd0;
                    1: unfair_thr = 8'd16;
                    2: unfair_thr = 8'd24;
                    3: unfair_thr = 8'd40;
                    default: unfair_thr = 8'd255;
                endcase
            end
            for (int e = 0; e < NE; e++) begin
                req_valid[e] = ($urandom % 10) < 6;
                req_tid[e]   = TW'($urandom % NT);
                req_bank[e]  = BW'($urandom % NB);
                req_row[e]   = RW'($urandom % 4);
                req_age[e]   = AW'($urandom % 8);
            end
            if (c % 97 == 0) req_valid = '0;
            for (int b = 0; b < NB; b++) begin
                bank_open[b] = $urandom % 2;
                bank_row[b]  = RW'($urandom % 4);
            end
            step("R8 random", 1'b1);
        end
        finish_run();
    end
endmodule